// File: doc/BRIEF.md
# Multiprocessor UART Receiver

This block is the receive half of an asynchronous serial port. It watches a resynchronised RX line with a strobe that fires sixteen times per bit. It assembles each character and places it in a one-entry receive buffer together with a set of error and address flags. The character format comes from a configuration word: 7 or 8 data bits, LSB-first or MSB-first order, optional odd or even parity, and one or two stop bits.

Two multiprocessor schemes let several nodes share one line. In idle-line mode, a character that follows a long run of marks is tagged as an address. In address-bit mode, an extra bit after the data (and after the parity bit, when parity is on) carries the tag. A dormant setting makes the receiver drop every character that is not an address. Reading the buffer clears the ready flag and all status flags. The buffer contents stay in place until the next character is loaded.

The frame controller is a state machine with six states:
- `S_IDLE`: waits for a falling edge on the line and moves to `S_START`.
- `S_START`: votes on the start bit at its midpoint. A high vote goes back to `S_IDLE` (false start); a low vote goes to `S_DATA`.
- `S_DATA`: after the last data bit, moves to `S_PAR` when parity is on. Otherwise it moves to `S_ADR` in address-bit mode, or to `S_STOP`.
- `S_PAR`: moves to `S_ADR` in address-bit mode, otherwise to `S_STOP`.
- `S_ADR`: moves to `S_STOP`.
- `S_STOP`: stays for a second stop bit when two are configured, then returns to `S_IDLE` and reports the character.

Top module: `mpuart_rx`

## Requirements
- R1: The configuration word packs these fields: bit 0 parity on, bit 1 parity sense (0 odd, 1 even), bit 2 order (0 LSB-first, 1 MSB-first), bit 3 seven-bit characters, bit 4 two stop bits, bits 6:5 multiprocessor scheme (00 none, 01 idle-line, 10 address-bit, 11 none), bit 7 dormant, bit 8 accept erroneous characters. Each bit is the majority of three samples at oversample counts 7, 8 and 9 of its bit time. The bit order follows bit 2.
- R2: In seven-bit mode the received value is right-aligned in `rx_data` and bit 7 reads 0.
- R3: With parity on, a character whose data bits plus parity bit hold an odd count of ones under even sense, or an even count under odd sense, sets the parity flag `rx_status[2]`. With parity off, the parity sense bit has no effect.
- R4: A low first or second stop bit sets the framing flag `rx_status[3]`.
- R5: A character in which every bit after the start bit is 0 sets the break flag `rx_status[4]`. The framing flag is set with it.
- R6: Loading a character while `rx_ready` is still high sets the overrun flag `rx_status[1]`. The buffer then holds the newer character.
- R7: In idle-line mode, a character that starts after more than 10 bit times of continuous mark is flagged as an address in `rx_status[0]`. A character that starts after a shorter gap is flagged as data.
- R8: In address-bit mode, the extra bit after the data and parity bits is copied to `rx_status[0]`: 1 for address, 0 for data.
- R9: When dormant, a character not tagged as an address changes nothing: `rx_data`, `rx_ready` and `rx_status` all keep their values. An address character loads normally.
- R10: With erroneous-character acceptance off, a character with a parity or framing error does not load the buffer and does not raise `rx_ready`. Its error flags are still recorded.
- R11: A pulse on `rd_strobe` clears `rx_ready` and every bit of `rx_status` in the next cycle, and leaves `rx_data` unchanged.
- R12: Reception begins only on a falling edge of the line. A low pulse that has ended before the midpoint of the start bit produces no character.
- R13: After reset, `rx_ready` is 0 and `rx_status` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_word | input | 9 | Character format and mode controls (R1) |
| rd_strobe | input | 1 | Buffer read; clears ready and status |
| rx_data | output | 8 | Receive buffer |
| rx_status | output | 5 | {break, framing, parity, overrun, address} |
| rx_ready | output | 1 | A character waits in the buffer |

## Verification
The bench sends randomly formatted frames mixed with directed cases and predicts each outcome from the bits it sent.

- Seven-bit frames of all ones expose a receiver that leaves the top buffer bit set or shifts the value one place.
- Frames with a flipped parity bit under both senses catch an inverted parity rule.
- A low second stop bit catches a receiver that checks only the first stop bit.
- Idle gaps on either side of the 10-bit threshold expose an address tag that is stuck at 1 or never set.
- Dormant data frames, erroneous frames with acceptance off, and a short glitch are each followed by a check that the buffer and ready flag did not move. A receiver that loaded them would show a new value there.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_ADR,
        S_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        MP_NONE = 2'b00,
        MP_IDLE = 2'b01,
        MP_ABIT = 2'b10,
        MP_RSVD = 2'b11
    } mp_mode_e;

    typedef struct packed {
        logic       err_accept;
        logic       dormant;
        logic [1:0] mp_mode;
        logic       two_stop;
        logic       seven_bit;
        logic       msb_first;
        logic       par_even;
        logic       par_en;
    } cfg_t;

    localparam int CFG_W  = $bits(cfg_t);
    localparam int STAT_W = 5;

endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mpuart_rx_idle.sv
module mpuart_rx_idle #(
    parameter int OSR       = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxs,
    input  logic busy,
    input  logic start_ok,
    output logic idle_pend
);
    localparam int THR = (IDLE_BITS + 1) * OSR;
    localparam int IW  = $clog2(THR + 1);

    logic [IW-1:0] gap_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (tick) begin
                if (busy || !rxs)              gap_q <= '0;
                else if (gap_q != IW'(THR))    gap_q <= gap_q + 1'b1;
            end
            if (start_ok)                   pend_q <= 1'b0;
            else if (gap_q == IW'(THR))     pend_q <= 1'b1;
        end
    end

    assign idle_pend = pend_q;
endmodule

// File: rtl/mpuart_rx_frame.sv
module mpuart_rx_frame
    import mpuart_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxs,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          msb_first,
    input  logic          seven_bit,
    input  logic          two_stop,
    input  logic [1:0]    mp_mode,
    input  logic          idle_pend,
    output logic          busy,
    output logic          start_ok,
    output logic          done,
    output logic [DW-1:0] d_data,
    output logic          d_addr,
    output logic          d_fe,
    output logic          d_pe,
    output logic          d_brk
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DW);
    localparam int MID = OSR / 2;

    rx_state_e state_q, state_d;

    logic [CW-1:0] cnt_q;
    logic          va_q, vb_q, prev_q;
    logic [DW-1:0] sh_q;
    logic [BW-1:0] bidx_q;
    logic          par_q, abit_q, sidx_q, fe_q, one_q, tag_q;
    logic          done_q, addr_q, fe_o_q, pe_o_q, brk_q;
    logic [DW-1:0] data_q;

    logic          decide, vote, last_data, last_stop;
    logic [BW-1:0] last_idx;
    logic [DW-1:0] data_asm;
    logic          pe_calc, addr_calc;

    assign decide    = tick && (state_q != S_IDLE) && (cnt_q == CW'(MID + 1));
    assign vote      = (va_q & vb_q) | (va_q & rxs) | (vb_q & rxs);
    assign last_idx  = seven_bit ? BW'(DW - 2) : BW'(DW - 1);
    assign last_data = (bidx_q == last_idx);
    assign last_stop = !two_stop || sidx_q;
    assign data_asm  = (!msb_first && seven_bit) ? (sh_q >> 1) : sh_q;
    assign pe_calc   = par_en && ((^data_asm ^ par_q) == par_even);
    assign addr_calc = (mp_mode == MP_ABIT) ? abit_q :
                       (mp_mode == MP_IDLE) ? tag_q  : 1'b0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (tick && prev_q && !rxs) state_d = S_START;
            S_START: if (decide) state_d = vote ? S_IDLE : S_DATA;
            S_DATA:  if (decide && last_data) begin
                         if (par_en)                 state_d = S_PAR;
                         else if (mp_mode == MP_ABIT) state_d = S_ADR;
                         else                        state_d = S_STOP;
                     end
            S_PAR:   if (decide) state_d = (mp_mode == MP_ABIT) ? S_ADR : S_STOP;
            S_ADR:   if (decide) state_d = S_STOP;
            S_STOP:  if (decide && last_stop) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign start_ok = decide && (state_q == S_START) && !vote;

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            va_q   <= 1'b1;
            vb_q   <= 1'b1;
            prev_q <= 1'b1;
            sh_q   <= '0;
            bidx_q <= '0;
            par_q  <= 1'b0;
            abit_q <= 1'b0;
            sidx_q <= 1'b0;
            fe_q   <= 1'b0;
            one_q  <= 1'b0;
            tag_q  <= 1'b0;
            done_q <= 1'b0;
            data_q <= '0;
            addr_q <= 1'b0;
            fe_o_q <= 1'b0;
            pe_o_q <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                prev_q <= rxs;
                if (state_q == S_IDLE)          cnt_q <= CW'(1);
                else if (cnt_q == CW'(OSR - 1)) cnt_q <= '0;
                else                            cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(MID - 1)) va_q <= rxs;
                if (cnt_q == CW'(MID))     vb_q <= rxs;
            end
            if (decide) begin
                unique case (state_q)
                    S_START: if (!vote) begin
                        sh_q   <= '0;
                        bidx_q <= '0;
                        one_q  <= 1'b0;
                        fe_q   <= 1'b0;
                        sidx_q <= 1'b0;
                        par_q  <= 1'b0;
                        abit_q <= 1'b0;
                        tag_q  <= idle_pend;
                    end
                    S_DATA: begin
                        sh_q   <= msb_first ? {sh_q[DW-2:0], vote} : {vote, sh_q[DW-1:1]};
                        bidx_q <= bidx_q + 1'b1;
                        one_q  <= one_q | vote;
                    end
                    S_PAR: begin
                        par_q <= vote;
                        one_q <= one_q | vote;
                    end
                    S_ADR: begin
                        abit_q <= vote;
                        one_q  <= one_q | vote;
                    end
                    S_STOP: begin
                        one_q  <= one_q | vote;
                        fe_q   <= fe_q | !vote;
                        sidx_q <= 1'b1;
                        if (last_stop) begin
                            done_q <= 1'b1;
                            data_q <= data_asm;
                            addr_q <= addr_calc;
                            fe_o_q <= fe_q | !vote;
                            pe_o_q <= pe_calc;
                            brk_q  <= !(one_q | vote);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy   = (state_q != S_IDLE);
    assign done   = done_q;
    assign d_data = data_q;
    assign d_addr = addr_q;
    assign d_fe   = fe_o_q;
    assign d_pe   = pe_o_q;
    assign d_brk  = brk_q;

    // R4 R5: a character is reported only as the machine leaves the stop field
    a_r4_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == S_IDLE));
    // R5: an all-zero character always carries a framing error
    a_r5_brk_has_fe: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && brk_q) |-> fe_o_q);
endmodule

// File: rtl/mpuart_rx_buf.sv
module mpuart_rx_buf
    import mpuart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DW-1:0]     d_data,
    input  logic              d_addr,
    input  logic              d_fe,
    input  logic              d_pe,
    input  logic              d_brk,
    input  logic              dormant,
    input  logic              err_accept,
    input  logic              rd,
    output logic [DW-1:0]     rx_data,
    output logic [STAT_W-1:0] rx_status,
    output logic              rx_ready
);
    logic [DW-1:0] data_q, data_d;
    logic          rdy_q, rdy_d;
    logic          brk_q, fe_q, pe_q, oe_q, adr_q;
    logic          brk_d, fe_d, pe_d, oe_d, adr_d;
    logic          take, load;

    assign take = done && (!dormant || d_addr);
    assign load = take && (!(d_fe || d_pe) || err_accept);

    always_comb begin
        data_d = data_q;
        rdy_d  = rd ? 1'b0 : rdy_q;
        brk_d  = rd ? 1'b0 : brk_q;
        fe_d   = rd ? 1'b0 : fe_q;
        pe_d   = rd ? 1'b0 : pe_q;
        oe_d   = rd ? 1'b0 : oe_q;
        adr_d  = rd ? 1'b0 : adr_q;
        if (take) begin
            brk_d = brk_d | d_brk;
            fe_d  = fe_d  | d_fe;
            pe_d  = pe_d  | d_pe;
        end
        if (load) begin
            oe_d   = oe_d | rdy_d;
            adr_d  = d_addr;
            data_d = d_data;
            rdy_d  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
            brk_q  <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
            oe_q   <= 1'b0;
            adr_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            rdy_q  <= rdy_d;
            brk_q  <= brk_d;
            fe_q   <= fe_d;
            pe_q   <= pe_d;
            oe_q   <= oe_d;
            adr_q  <= adr_d;
        end
    end

    assign rx_data   = data_q;
    assign rx_status = {brk_q, fe_q, pe_q, oe_q, adr_q};
    assign rx_ready  = rdy_q;

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!rdy_q && rx_status == '0));
    a_r9_dormant_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dormant && !d_addr && !rd) |=> ($stable(data_q) && $stable(rdy_q)));
    a_r10_err_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (d_fe || d_pe) && !err_accept && !rd) |=> ($stable(data_q) && $stable(rdy_q)));
    a_r6_oe_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(rdy_q));
    a_r5_brk_with_fe: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> fe_q);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DW          = 8,
    parameter int IDLE_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              rd_strobe,
    output logic [DW-1:0]     rx_data,
    output logic [STAT_W-1:0] rx_status,
    output logic              rx_ready
);
    cfg_t          cfg;
    logic          rxs, busy, start_ok, idle_pend;
    logic          done, d_addr, d_fe, d_pe, d_brk;
    logic [DW-1:0] d_data;

    assign cfg = cfg_t'(cfg_word);

    mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .d_out (rxs)
    );

    mpuart_rx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rxs       (rxs),
        .busy      (busy),
        .start_ok  (start_ok),
        .idle_pend (idle_pend)
    );

    mpuart_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rxs       (rxs),
        .par_en    (cfg.par_en),
        .par_even  (cfg.par_even),
        .msb_first (cfg.msb_first),
        .seven_bit (cfg.seven_bit),
        .two_stop  (cfg.two_stop),
        .mp_mode   (cfg.mp_mode),
        .idle_pend (idle_pend),
        .busy      (busy),
        .start_ok  (start_ok),
        .done      (done),
        .d_data    (d_data),
        .d_addr    (d_addr),
        .d_fe      (d_fe),
        .d_pe      (d_pe),
        .d_brk     (d_brk)
    );

    mpuart_rx_buf #(.DW(DW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .d_data     (d_data),
        .d_addr     (d_addr),
        .d_fe       (d_fe),
        .d_pe       (d_pe),
        .d_brk      (d_brk),
        .dormant    (cfg.dormant),
        .err_accept (cfg.err_accept),
        .rd         (rd_strobe),
        .rx_data    (rx_data),
        .rx_status  (rx_status),
        .rx_ready   (rx_ready)
    );
endmodule

// File: tb/sim_mpuart_rx.sv
module sim_mpuart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [8:0] cfg_word = '0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic [4:0] rx_status;
    logic       rx_ready;

    int n_cmp = 0;
    int n_bad = 0;

    logic       m_ready = 1'b0;
    logic [7:0] m_buf = '0;
    logic [4:0] m_stat = '0;

    always #4 clk = ~clk;

    always @(posedge clk) os_tick <= ~os_tick;

    mpuart_rx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_in     (rx_in),
        .cfg_word  (cfg_word),
        .rd_strobe (rd_strobe),
        .rx_data   (rx_data),
        .rx_status (rx_status),
        .rx_ready  (rx_ready)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(posedge clk iff os_tick);
        #1;
    endtask

    task automatic send_bit(input logic b);
        rx_in = b;
        wait_ticks(16);
    endtask

    function automatic logic [8:0] mk_cfg(input logic acc, input logic dorm, input logic [1:0] mode,
                                          input logic two, input logic seven, input logic msb,
                                          input logic even, input logic pen);
        return {acc, dorm, mode, two, seven, msb, even, pen};
    endfunction

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        chk("R11 ready after read", {31'd0, rx_ready}, 32'd0);
        chk("R11 status after read", {27'd0, rx_status}, 32'd0);
        chk("R11 data kept on read", {24'd0, rx_data}, {24'd0, m_buf});
        m_ready = 1'b0;
        m_stat  = '0;
    endtask

    task automatic run_case(input string rq, input logic [8:0] c, input logic [7:0] d,
                            input logic abit, input logic pflip, input logic s1, input logic s2,
                            input logic longgap, input logic rd_after);
        logic [7:0] dm;
        logic       pen, even, msb, seven, two, dorm, acc;
        logic [1:0] mode;
        logic       pbit, allz, fe, pe, isaddr, err;
        int         nb;
        pen = c[0]; even = c[1]; msb = c[2]; seven = c[3]; two = c[4];
        mode = c[6:5]; dorm = c[7]; acc = c[8];
        nb = seven ? 7 : 8;
        dm = seven ? (d & 8'h7F) : d;
        pbit = (even ? ^dm : ~(^dm)) ^ pflip;
        cfg_word = c;
        rx_in = 1'b1;
        wait_ticks(longgap ? 12 * 16 : 2 * 16);
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(msb ? dm[nb - 1 - i] : dm[i]);
        if (pen) send_bit(pbit);
        if (mode == 2'b10) send_bit(abit);
        send_bit(s1);
        if (two) send_bit(s2);
        rx_in = 1'b1;
        wait_ticks(2);
        @(negedge clk);
        allz   = (dm == 8'h00) && (!pen || !pbit) && (mode != 2'b10 || !abit) && !s1 && (!two || !s2);
        fe     = !s1 || (two && !s2);
        pe     = pen && pflip;
        isaddr = (mode == 2'b10) ? abit : (mode == 2'b01) ? longgap : 1'b0;
        err    = fe || pe;
        if (!dorm || isaddr) begin
            m_stat[4] = m_stat[4] | allz;
            m_stat[3] = m_stat[3] | fe;
            m_stat[2] = m_stat[2] | pe;
            if (!err || acc) begin
                m_stat[1] = m_stat[1] | m_ready;
                m_stat[0] = isaddr;
                m_buf     = dm;
                m_ready   = 1'b1;
            end
        end
        chk({rq, " ready"},  {31'd0, rx_ready},  {31'd0, m_ready});
        chk({rq, " data"},   {24'd0, rx_data},   {24'd0, m_buf});
        chk({rq, " status"}, {27'd0, rx_status}, {27'd0, m_stat});
        if (rd_after) do_read();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 ready", {31'd0, rx_ready}, 32'd0);
        chk("R13 status", {27'd0, rx_status}, 32'd0);
        chk("R13 data", {24'd0, rx_data}, 32'd0);

        // R1 plain LSB-first and MSB-first
        run_case("R1 lsb", mk_cfg(0,0,2'b00,0,0,0,0,0), 8'hA6, 0, 0, 1, 1, 0, 1);
        run_case("R1 msb", mk_cfg(0,0,2'b00,0,0,1,0,0), 8'h3C, 0, 0, 1, 1, 0, 1);
        // R2 seven-bit alignment
        run_case("R2 lsb7", mk_cfg(0,0,2'b00,0,1,0,0,0), 8'hFF, 0, 0, 1, 1, 0, 1);
        run_case("R2 msb7", mk_cfg(0,0,2'b00,0,1,1,0,0), 8'h55, 0, 0, 1, 1, 0, 1);
        // R3 parity good and bad, both senses
        run_case("R3 even ok", mk_cfg(1,0,2'b00,0,0,0,1,1), 8'h13, 0, 0, 1, 1, 0, 1);
        run_case("R3 odd bad", mk_cfg(1,0,2'b00,0,0,0,0,1), 8'h13, 0, 1, 1, 1, 0, 1);
        run_case("R3 even bad", mk_cfg(1,0,2'b00,0,0,0,1,1), 8'h80, 0, 1, 1, 1, 0, 1);
        run_case("R3 sense ignored", mk_cfg(0,0,2'b00,0,0,0,1,0), 8'h07, 0, 0, 1, 1, 0, 1);
        // R4 framing on second stop
        run_case("R4 stop2 low", mk_cfg(1,0,2'b00,1,0,0,0,0), 8'h5A, 0, 0, 1, 0, 0, 1);
        run_case("R4 stop1 low", mk_cfg(1,0,2'b00,0,0,0,0,0), 8'hC3, 0, 0, 0, 1, 0, 1);
        // R5 break
        run_case("R5 break", mk_cfg(1,0,2'b00,0,0,0,0,0), 8'h00, 0, 0, 0, 1, 1, 1);
        // R6 overrun
        run_case("R6 first", mk_cfg(0,0,2'b00,0,0,0,0,0), 8'h11, 0, 0, 1, 1, 0, 0);
        run_case("R6 second", mk_cfg(0,0,2'b00,0,0,0,0,0), 8'h22, 0, 0, 1, 1, 0, 1);
        // R7 idle-line tagging
        run_case("R7 long gap", mk_cfg(0,0,2'b01,0,0,0,0,0), 8'h41, 0, 0, 1, 1, 1, 1);
        run_case("R7 short gap", mk_cfg(0,0,2'b01,0,0,0,0,0), 8'h42, 0, 0, 1, 1, 0, 1);
        // R8 address bit
        run_case("R8 addr", mk_cfg(0,0,2'b10,0,0,0,0,1), 8'h9E, 1, 0, 1, 1, 0, 1);
        run_case("R8 data", mk_cfg(0,0,2'b10,0,0,0,0,1), 8'h9F, 0, 0, 1, 1, 0, 1);
        // R9 dormant
        run_case("R9 dormant data", mk_cfg(0,1,2'b10,0,0,0,0,0), 8'h6D, 0, 0, 1, 1, 0, 1);
        run_case("R9 dormant addr", mk_cfg(0,1,2'b10,0,0,0,0,0), 8'h6E, 1, 0, 1, 1, 0, 1);
        run_case("R9 dormant idle", mk_cfg(0,1,2'b01,0,0,0,0,0), 8'h6F, 0, 0, 1, 1, 0, 1);
        // R10 error rejection
        run_case("R10 parity reject", mk_cfg(0,0,2'b00,0,0,0,1,1), 8'hB4, 0, 1, 1, 1, 0, 1);
        run_case("R10 frame reject", mk_cfg(0,0,2'b00,0,0,0,0,0), 8'hB5, 0, 0, 0, 1, 0, 1);

        // R12 glitch shorter than half a bit
        rx_in = 1'b1;
        wait_ticks(32);
        rx_in = 1'b0;
        wait_ticks(3);
        rx_in = 1'b1;
        wait_ticks(40);
        @(negedge clk);
        chk("R12 glitch ready", {31'd0, rx_ready}, 32'd0);
        chk("R12 glitch data", {24'd0, rx_data}, {24'd0, m_buf});
        run_case("R12 after glitch", mk_cfg(0,0,2'b00,0,0,0,0,0), 8'hE7, 0, 0, 1, 1, 1, 1);

        // random mix
        for (int k = 0; k < 70; k++) begin
            logic [1:0] md;
            logic [8:0] c;
            md = 2'($urandom % 3);
            c = mk_cfg(1'($urandom), ($urandom % 4) == 0, md, 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), 1'($urandom));
            run_case("R1 random", c, 8'($urandom), 1'($urandom), ($urandom % 4) == 0,
                     ($urandom % 6) != 0, ($urandom % 6) != 0, 1'($urandom), 1'($urandom));
        end
        do_read();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule